// File: doc/BRIEF.md
# Bit-Serial FPGA Configuration Master

This block loads a target FPGA through a one-bit serial configuration port. A single `start` strobe captures a byte length, after which the block runs a start-up handshake with the target. First it holds the active-low clear pin low until the target reports that it is clearing, by pulling its active-low wait pin low. It then releases the clear pin and waits for the target to let the wait pin go high again. Each of these two waits has its own timeout.

Once the target is ready, bytes arrive on an upstream valid/ready stream and go out on a data pin one bit per pulse of the configuration clock, most significant bit first. Before each byte the block looks at the target's finished and wait pins. A finished target ends the data phase early, while an active wait pin at that point means a configuration error. After the data phase the block keeps clocking filler ones until the target confirms completion, or until a second timeout expires.

A readback request is answered at once with a failure, because this port cannot read back. The `busy`, pass and fail outputs report the outcome, and they hold their values until the next start.

Top module: `serial_cfg_master`

## Requirements
- R1: After reset and whenever `busy` is low, `cfg_clear_n`, `cfg_sclk` and `cfg_sdata` are all high. After reset, `busy`, `cfg_pass`, `cfg_fail`, `fail_cause` and `s_ready` are all zero.
- R2: Start-up runs as follows:
  - `start` drives `cfg_clear_n` low.
  - `cfg_clear_n` returns high only after `cfg_wait_n` has been seen low.
  - No clock pulse is sent while `cfg_clear_n` is low.
  - No clock pulse is sent before `cfg_wait_n` has gone high again.
- R3: The start-up waits have a timeout of `INIT_WAIT` cycles each:
  - If `cfg_wait_n` never goes low, the run fails with `fail_cause` 1.
  - If `cfg_wait_n` never goes high again, the run fails with `fail_cause` 2.
  - In both cases `cfg_clear_n` is high again when `busy` falls.
- R4: Each byte is sent as eight clock pulses, bit 7 first and bit 0 last. `cfg_sdata` is set in the cycle in which `cfg_sclk` falls. It is unchanged in the cycle in which `cfg_sclk` rises, and the target samples it on that rising edge.
- R5: `s_ready` is high only in the data phase, only while the one-byte holding register is empty, and only until `byte_len` bytes have been accepted. A byte is taken when `s_valid` and `s_ready` are both high at a clock edge. The next byte may be taken while the previous one is being shifted out.
- R6: At every byte boundary the block samples `cfg_finished` before any other check. If it is high, no further data bits are sent and the filler phase begins. A `byte_len` of zero goes straight to the filler phase.
- R7: If `cfg_wait_n` is low at a byte boundary while `cfg_finished` is low, the run fails with `fail_cause` 3 and no further clock pulse is sent.
- R8: In the filler phase `cfg_sdata` is 1 on every pulse. The block checks once per pulse. It passes when `cfg_finished` is high and `cfg_wait_n` is high on `DONE_CONFIRM`+1 consecutive checks, which means `DONE_CONFIRM` filler pulses after the first good check.
- R9: If the filler phase has not passed within `FILL_WAIT` cycles, the run fails with `fail_cause` 4.
- R10: `readback_req` while idle, without `start`, sets `cfg_fail` and `fail_cause` 5 in the next cycle. `busy` stays low and no pin moves.
- R11: Timing of `busy` and of the result:
  - `busy` is high from the cycle after `start` until the cycle in which the result appears.
  - `cfg_pass` and `cfg_fail` are both zero while `busy` is high.
  - `cfg_pass` and `cfg_fail` are never high together.
  - The result holds until the next `start`.
  - `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run (idle only) |
| readback_req | input | 1 | Readback request, always rejected |
| byte_len | input | LEN_W | Number of bytes to send, captured on start |
| s_valid | input | 1 | Upstream byte valid |
| s_data | input | 8 | Upstream byte |
| s_ready | output | 1 | Upstream byte accepted when high with s_valid |
| busy | output | 1 | Run in progress |
| cfg_pass | output | 1 | Last run completed |
| cfg_fail | output | 1 | Last run or request failed |
| fail_cause | output | 3 | 0 none, 1 wait-low timeout, 2 wait-release timeout, 3 wait active during load, 4 finish timeout, 5 readback rejected |
| cfg_clear_n | output | 1 | Active-low clear to the target |
| cfg_sclk | output | 1 | Configuration clock, data sampled on rising edge |
| cfg_sdata | output | 1 | Serial configuration data |
| cfg_wait_n | input | 1 | Target wait/error, active low |
| cfg_finished | input | 1 | Target reports configuration complete |

## Verification
The critical coincidence is at a byte boundary. There, the early-finish check and the launch of the next, already buffered byte fall in the same cycle. The bench's target model raises `cfg_finished` right after the sixteenth rising clock edge while the third byte already sits in the holding register. That third byte is all zeros, so any of its bits that leaked out would show up as zeros where only filler ones are allowed. The run is judged by the captured bit sequence, by exactly eight filler pulses and by an accepted byte count of three.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    localparam int        BYTE_BITS = 8;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_REL,
        ST_LOAD,
        ST_FILL
    } state_e;

    typedef enum logic [2:0] {
        FC_NONE        = 3'd0,
        FC_INIT_TO     = 3'd1,
        FC_REL_TO      = 3'd2,
        FC_INIT_ERR    = 3'd3,
        FC_DONE_TO     = 3'd4,
        FC_NO_READBACK = 3'd5
    } fail_e;

    typedef struct packed {
        logic  busy;
        logic  pass;
        logic  fail;
        fail_e cause;
    } status_t;

    function automatic status_t status_run();
        status_t s;
        s.busy  = 1'b1;
        s.pass  = 1'b0;
        s.fail  = 1'b0;
        s.cause = FC_NONE;
        return s;
    endfunction

    function automatic status_t status_end(input logic ok, input fail_e why);
        status_t s;
        s.busy  = 1'b0;
        s.pass  = ok;
        s.fail  = ~ok;
        s.cause = ok ? FC_NONE : why;
        return s;
    endfunction

endpackage

// File: rtl/scfg_timer.sv
module scfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + W'(1);
        end
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/scfg_hold.sv
module scfg_hold #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [LEN_W-1:0] total,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    input  logic             take,
    output logic             hold_valid,
    output logic [7:0]       hold_data
);
    logic [LEN_W-1:0] got;

    assign s_ready = en && !hold_valid && (got < total);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            got        <= '0;
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else begin
            if (s_valid && s_ready) begin
                hold_data  <= s_data;
                hold_valid <= 1'b1;
                got        <= got + LEN_W'(1);
            end else if (take) begin
                hold_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter
    import scfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] go_byte,
    input  logic [3:0] go_bits,
    output logic       empty,
    output logic       sclk,
    output logic       sdata
);
    logic [7:0] sr;
    logic [3:0] left;
    logic       high_half;

    assign empty = (left == 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            left      <= '0;
            high_half <= 1'b0;
            sclk      <= 1'b1;
            sdata     <= 1'b1;
        end else if (go) begin
            sr        <= go_byte;
            left      <= go_bits;
            high_half <= 1'b0;
        end else if (!empty) begin
            if (!high_half) begin
                sdata     <= sr[BYTE_BITS-1];
                sclk      <= 1'b0;
                high_half <= 1'b1;
            end else begin
                sclk      <= 1'b1;
                sr        <= {sr[BYTE_BITS-2:0], 1'b0};
                left      <= left - 4'd1;
                high_half <= 1'b0;
            end
        end else begin
            sdata <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_cfg_master.sv
module serial_cfg_master
    import scfg_pkg::*;
#(
    parameter int LEN_W        = 24,
    parameter int INIT_WAIT    = 25_000_000,
    parameter int FILL_WAIT    = 10_000_000,
    parameter int DONE_CONFIRM = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             readback_req,
    input  logic [LEN_W-1:0] byte_len,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    output logic             busy,
    output logic             cfg_pass,
    output logic             cfg_fail,
    output logic [2:0]       fail_cause,
    output logic             cfg_clear_n,
    output logic             cfg_sclk,
    output logic             cfg_sdata,
    input  logic             cfg_wait_n,
    input  logic             cfg_finished
);
    localparam int MAX_WAIT = (INIT_WAIT > FILL_WAIT) ? INIT_WAIT : FILL_WAIT;
    localparam int TMR_W    = $clog2(MAX_WAIT + 1);
    localparam int CONF_W   = $clog2(DONE_CONFIRM + 1);
    localparam logic [TMR_W-1:0]  INIT_LIM = TMR_W'(INIT_WAIT);
    localparam logic [TMR_W-1:0]  FILL_LIM = TMR_W'(FILL_WAIT);
    localparam logic [CONF_W-1:0] CONF_MAX = CONF_W'(DONE_CONFIRM);

    state_e            st, st_d;
    status_t           stat, stat_d;
    logic              clear_q, clear_d;
    logic [LEN_W-1:0]  len_q, len_d, sent_q, sent_d;
    logic [CONF_W-1:0] conf_q, conf_d;

    logic              tmr_clr, tmr_exp;
    logic [TMR_W-1:0]  tmr_lim;
    logic              hold_clr, take, hold_valid;
    logic [7:0]        hold_data;
    logic              go, sh_empty;
    logic [7:0]        go_byte;
    logic [3:0]        go_bits;

    logic wait_active, finish_good;
    assign wait_active = ~cfg_wait_n;
    assign finish_good = cfg_finished && !wait_active;

    always_comb begin
        st_d     = st;
        stat_d   = stat;
        clear_d  = clear_q;
        len_d    = len_q;
        sent_d   = sent_q;
        conf_d   = conf_q;
        go       = 1'b0;
        go_byte  = FILL_BYTE;
        go_bits  = 4'd1;
        take     = 1'b0;
        tmr_clr  = 1'b0;
        hold_clr = 1'b0;
        tmr_lim  = (st == ST_FILL) ? FILL_LIM : INIT_LIM;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    st_d     = ST_PROG;
                    stat_d   = status_run();
                    clear_d  = 1'b0;
                    len_d    = byte_len;
                    sent_d   = '0;
                    tmr_clr  = 1'b1;
                    hold_clr = 1'b1;
                end else if (readback_req) begin
                    stat_d = status_end(1'b0, FC_NO_READBACK);
                end
            end
            ST_PROG: begin
                if (wait_active) begin
                    clear_d = 1'b1;
                    st_d    = ST_REL;
                    tmr_clr = 1'b1;
                end else if (tmr_exp) begin
                    clear_d = 1'b1;
                    st_d    = ST_IDLE;
                    stat_d  = status_end(1'b0, FC_INIT_TO);
                end
            end
            ST_REL: begin
                if (!wait_active) begin
                    st_d = ST_LOAD;
                end else if (tmr_exp) begin
                    st_d   = ST_IDLE;
                    stat_d = status_end(1'b0, FC_REL_TO);
                end
            end
            ST_LOAD: begin
                if (sh_empty) begin
                    if (sent_q == len_q || cfg_finished) begin
                        st_d    = ST_FILL;
                        tmr_clr = 1'b1;
                        conf_d  = '0;
                    end else if (wait_active) begin
                        st_d   = ST_IDLE;
                        stat_d = status_end(1'b0, FC_INIT_ERR);
                    end else if (hold_valid) begin
                        go      = 1'b1;
                        go_byte = hold_data;
                        go_bits = 4'(BYTE_BITS);
                        take    = 1'b1;
                        sent_d  = sent_q + LEN_W'(1);
                    end
                end
            end
            ST_FILL: begin
                if (sh_empty) begin
                    if (finish_good && conf_q == CONF_MAX) begin
                        st_d   = ST_IDLE;
                        stat_d = status_end(1'b1, FC_NONE);
                    end else if (tmr_exp) begin
                        st_d   = ST_IDLE;
                        stat_d = status_end(1'b0, FC_DONE_TO);
                    end else begin
                        go     = 1'b1;
                        conf_d = finish_good ? conf_q + CONF_W'(1) : '0;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            stat    <= '0;
            clear_q <= 1'b1;
            len_q   <= '0;
            sent_q  <= '0;
            conf_q  <= '0;
        end else begin
            st      <= st_d;
            stat    <= stat_d;
            clear_q <= clear_d;
            len_q   <= len_d;
            sent_q  <= sent_d;
            conf_q  <= conf_d;
        end
    end

    scfg_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .limit   (tmr_lim),
        .expired (tmr_exp)
    );

    scfg_hold #(.LEN_W(LEN_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .clr        (hold_clr),
        .en         (st == ST_LOAD),
        .total      (len_q),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_ready    (s_ready),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data)
    );

    scfg_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .go_byte (go_byte),
        .go_bits (go_bits),
        .empty   (sh_empty),
        .sclk    (cfg_sclk),
        .sdata   (cfg_sdata)
    );

    assign busy        = stat.busy;
    assign cfg_pass    = stat.pass;
    assign cfg_fail    = stat.fail;
    assign fail_cause  = stat.cause;
    assign cfg_clear_n = clear_q;
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic readback_req,
    input logic busy,
    input logic cfg_pass,
    input logic cfg_fail,
    input logic cfg_clear_n,
    input logic cfg_sclk,
    input logic cfg_sdata,
    input logic s_ready
);
    // R1
    idle_pins_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cfg_sclk && cfg_sdata && cfg_clear_n));

    // R2
    no_clock_in_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_clear_n |-> cfg_sclk);

    // R4
    data_steady_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_sclk) |-> $stable(cfg_sdata));

    // R5
    ready_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> busy);

    // R10
    readback_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (readback_req && !start && !busy) |=> (cfg_fail && !busy && cfg_clear_n));

    // R11
    result_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_pass && cfg_fail));

    // R11
    no_result_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(cfg_pass || cfg_fail));

    // R11
    result_held_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !readback_req) |=> ($stable(cfg_pass) && !busy));
endmodule

bind serial_cfg_master scfg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .readback_req (readback_req),
    .busy         (busy),
    .cfg_pass     (cfg_pass),
    .cfg_fail     (cfg_fail),
    .cfg_clear_n  (cfg_clear_n),
    .cfg_sclk     (cfg_sclk),
    .cfg_sdata    (cfg_sdata),
    .s_ready      (s_ready)
);

// File: tb/serial_cfg_master_tb.sv
`timescale 1ns/1ps
module serial_cfg_master_tb;
    localparam int LEN_W     = 16;
    localparam int INIT_WAIT = 300;
    localparam int FILL_WAIT = 400;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             readback_req = 1'b0;
    logic [LEN_W-1:0] byte_len = '0;
    logic             s_valid = 1'b0;
    logic [7:0]       s_data = '0;
    logic             s_ready, busy, cfg_pass, cfg_fail;
    logic [2:0]       fail_cause;
    logic             cfg_clear_n, cfg_sclk, cfg_sdata;
    logic             cfg_wait_n = 1'b1;
    logic             cfg_finished = 1'b0;

    always #10 clk = ~clk;

    serial_cfg_master #(
        .LEN_W(LEN_W), .INIT_WAIT(INIT_WAIT), .FILL_WAIT(FILL_WAIT), .DONE_CONFIRM(8)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .readback_req(readback_req),
        .byte_len(byte_len), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .busy(busy), .cfg_pass(cfg_pass), .cfg_fail(cfg_fail), .fail_cause(fail_cause),
        .cfg_clear_n(cfg_clear_n), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
        .cfg_wait_n(cfg_wait_n), .cfg_finished(cfg_finished)
    );

    // target behaviour controls (written by the test sequence only)
    int tgt_mode = 0;      // 0 normal, 1 never pulls wait low, 2 never releases wait
    int done_at  = 1000000;
    int err_at   = 1000000;

    // target model and per-clock monitor (sole writer of these)
    bit cap_q[$];
    int bit_cnt = 0, clr_low = 0, rel_cnt = 0, clear_falls = 0;
    bit released = 0, prev_sclk = 1, prev_clear = 1;
    int mon_vec = 0, mon_err = 0;

    always @(negedge clk) begin
        if (rst) begin
            cfg_wait_n   = 1'b1;
            cfg_finished = 1'b0;
            prev_sclk    = 1'b1;
            prev_clear   = 1'b1;
        end else begin
            mon_vec++;
            if (!busy && !(cfg_sclk && cfg_sdata && cfg_clear_n)) begin
                mon_err++;
                $display("FAIL R1 idle pins act=%b%b%b exp=111", cfg_clear_n, cfg_sclk, cfg_sdata);
            end
            mon_vec++;
            if (!cfg_clear_n && !cfg_sclk) begin
                mon_err++;
                $display("FAIL R2 clock low during clear act=%b exp=1", cfg_sclk);
            end
            mon_vec++;
            if (cfg_pass && cfg_fail) begin
                mon_err++;
                $display("FAIL R11 pass and fail act=11 exp=not both");
            end
            if (prev_clear && !cfg_clear_n) begin
                cap_q.delete();
                bit_cnt      = 0;
                clr_low      = 0;
                rel_cnt      = 0;
                released     = 0;
                cfg_wait_n   = 1'b1;
                cfg_finished = 1'b0;
                clear_falls++;
            end
            if (!cfg_clear_n) begin
                clr_low++;
                if (tgt_mode != 1 && clr_low >= 3) cfg_wait_n = 1'b0;
            end else if (!cfg_wait_n && !released) begin
                rel_cnt++;
                if (tgt_mode != 2 && rel_cnt >= 4) begin
                    cfg_wait_n = 1'b1;
                    released   = 1;
                end
            end
            if (!prev_sclk && cfg_sclk) begin
                mon_vec++;
                if (!released) begin
                    mon_err++;
                    $display("FAIL R2 clock pulse before wait released act=0 exp=1");
                end
                cap_q.push_back(cfg_sdata);
                bit_cnt++;
                if (bit_cnt == done_at) cfg_finished = 1'b1;
                if (bit_cnt == err_at)  cfg_wait_n   = 1'b0;
            end
            prev_sclk  = cfg_sclk;
            prev_clear = cfg_clear_n;
        end
    end

    int tst_vec = 0, tst_err = 0, wd_err = 0, n_acc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tst_vec++;
        if (!ok) begin
            tst_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==",
                 mon_vec + tst_vec, mon_err + tst_err + wd_err);
    endtask

    task automatic drive_stream(input logic [7:0] b[$], input int g[$]);
        for (int i = 0; i < b.size(); i++) begin
            repeat (g[i]) @(negedge clk);
            if (!busy) break;
            s_valid = 1'b1;
            s_data  = b[i];
            while (!s_ready && busy) @(negedge clk);
            if (!s_ready) begin
                s_valid = 1'b0;
                break;
            end
            @(posedge clk);
            n_acc++;
            @(negedge clk);
            s_valid = 1'b0;
        end
        s_valid = 1'b0;
    endtask

    task automatic run_cfg(input int len, input logic [7:0] b[$], input int g[$],
                           input int restart_at, output int bcyc);
        n_acc = 0;
        @(negedge clk);
        byte_len = LEN_W'(len);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11 status cleared and busy raised by start
        chk(busy && !cfg_pass && !cfg_fail, "R11 start clears status", {busy, cfg_pass, cfg_fail}, 3'b100);
        fork
            drive_stream(b, g);
        join_none
        bcyc = 1;
        while (busy) begin
            start = (bcyc == restart_at);
            @(negedge clk);
            bcyc++;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // data bits MSB first for the first ndata bits, then filler ones
    task automatic chk_bits(input logic [7:0] b[$], input int ndata, input int total, input string req);
        chk(cap_q.size() == total, {req, " pulse count"}, cap_q.size(), total);
        for (int i = 0; i < cap_q.size(); i++) begin
            bit e;
            e = (i < ndata) ? b[i/8][7 - (i%8)] : 1'b1;
            chk(cap_q[i] == e, {req, " bit value"}, cap_q[i], e);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        wd_err = 1;
        $display("FAIL watchdog expired act=running exp=finished");
        report();
        $finish;
    end

    initial begin : main
        logic [7:0] b[$];
        int g[$];
        int bc;
        int falls0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({cfg_clear_n, cfg_sclk, cfg_sdata} == 3'b111, "R1 reset pins", {cfg_clear_n, cfg_sclk, cfg_sdata}, 7);
        chk({busy, cfg_pass, cfg_fail, s_ready} == 4'b0, "R1 reset status", {busy, cfg_pass, cfg_fail, s_ready}, 0);
        chk(fail_cause == 3'd0, "R1 reset cause", fail_cause, 0);

        // R4 R5 R8 normal load
        tgt_mode = 0; done_at = 36; err_at = 1000000;
        b = '{8'hA5, 8'h3C, 8'h96, 8'h0F}; g = '{0, 0, 0, 0};
        run_cfg(4, b, g, -1, bc);
        chk(cfg_pass && !cfg_fail, "R8 normal pass", {cfg_pass, cfg_fail}, 2);
        chk_bits(b, 32, 44, "R4");
        chk(n_acc == 4, "R5 bytes accepted", n_acc, 4);
        chk(clear_falls == 1, "R2 one clear pulse", clear_falls, 1);

        // R5 R4 upstream stalls
        done_at = 33;
        b = '{8'h00, 8'hFF, 8'h81, 8'h7E}; g = '{0, 25, 7, 40};
        run_cfg(4, b, g, -1, bc);
        chk(cfg_pass, "R5 stalled pass", cfg_pass, 1);
        chk_bits(b, 32, 41, "R5");
        chk(n_acc == 4, "R5 stalled accepted", n_acc, 4);

        // R6 early finish coinciding with buffered next byte
        done_at = 16;
        b = '{8'hF0, 8'h0F, 8'h00, 8'h00}; g = '{0, 0, 0, 0};
        run_cfg(4, b, g, -1, bc);
        chk(cfg_pass, "R6 early pass", cfg_pass, 1);
        chk_bits(b, 16, 24, "R6");
        chk(n_acc == 3, "R6 bytes accepted", n_acc, 3);

        // R7 wait asserted during load
        done_at = 1000000; err_at = 8;
        b = '{8'hC3, 8'h00, 8'h00}; g = '{0, 0, 0};
        run_cfg(3, b, g, -1, bc);
        chk(cfg_fail && fail_cause == 3'd3, "R7 load error", fail_cause, 3);
        chk_bits(b, 8, 8, "R7");

        // R3 wait never asserts
        err_at = 1000000; tgt_mode = 1;
        b = '{8'h11}; g = '{0};
        run_cfg(1, b, g, -1, bc);
        chk(cfg_fail && fail_cause == 3'd1, "R3 assert timeout cause", fail_cause, 1);
        chk(bc >= INIT_WAIT && bc <= INIT_WAIT + 6, "R3 assert timeout length", bc, INIT_WAIT);
        chk(cap_q.size() == 0 && cfg_clear_n, "R3 no pulses, clear released", cap_q.size(), 0);

        // R3 wait never released
        tgt_mode = 2;
        run_cfg(1, b, g, -1, bc);
        chk(cfg_fail && fail_cause == 3'd2, "R3 release timeout cause", fail_cause, 2);
        chk(cap_q.size() == 0 && cfg_clear_n, "R3 release no pulses", cap_q.size(), 0);

        // R9 finish never arrives
        tgt_mode = 0; done_at = 1000000;
        b = '{8'h55}; g = '{0};
        run_cfg(1, b, g, -1, bc);
        chk(cfg_fail && fail_cause == 3'd4, "R9 finish timeout", fail_cause, 4);
        chk(cap_q.size() > 8, "R9 filler sent", cap_q.size(), 9);
        chk_bits(b, 8, cap_q.size(), "R9");

        // R10 readback rejected
        falls0 = clear_falls;
        @(negedge clk);
        readback_req = 1'b1;
        @(negedge clk);
        readback_req = 1'b0;
        chk(cfg_fail && !cfg_pass && fail_cause == 3'd5, "R10 readback cause", fail_cause, 5);
        chk(!busy && cfg_clear_n && clear_falls == falls0, "R10 no activity", busy, 0);

        // R6 R11 zero length, start while busy ignored
        done_at = 2;
        b = '{}; g = '{};
        run_cfg(0, b, g, 40, bc);
        chk(cfg_pass, "R6 zero length pass", cfg_pass, 1);
        chk_bits(b, 0, 10, "R6 zero length");
        chk(clear_falls == falls0 + 1, "R11 restart ignored", clear_falls, falls0 + 1);

        // R11 result held until next start
        repeat (30) @(negedge clk);
        chk(cfg_pass && !cfg_fail && !busy, "R11 result held", {cfg_pass, cfg_fail}, 2);

        report();
        $finish;
    end
endmodule